// File: doc/BRIEF.md
# Dual-Tag Late-Binding Message Cache

This block is a small fully associative write-back cache that holds arriving network messages, one message per line, and later hands a line over to the consuming process without moving its data. Every line carries three tags: an address in the network buffer space, an address in the process space, and a message identifier. The line's state decides which tags count. An unbound line answers to its network address and its identifier. A bound line answers only to its process address.

A remap command names a message identifier and the physical process address that receives it. On a hit, the line is rebound in place. If the message was evicted earlier, a small link table still holds its identifier and buffer address. The line is then read back through the memory port and bound when the data returns. The remap handshake stays stalled for the whole of that wait. Victims are taken from bound lines first, least recently used. Only when no line is bound does an externally supplied hint pick an unbound line, meaning the message least likely to be consumed next.

Top module: `dual_tag_netcache`

## Requirements
- R1: After reset no line is occupied, every response and memory request output is low and `rmp_ready` is high.
- R2: An accepted arrival fills a line as unbound with its buffer address and identifier. A network-port access to that address hits one cycle later and returns the line. A process-port access to the same address misses.
- R3: An arrival whose `arr_len` exceeds LINE_WORDS raises `arr_err` in the next cycle and stores nothing, so a network access to its address misses.
- R4: A network-port store (`net_we`=1) that hits replaces the whole line, and the new value is returned on later hits.
- R5: A remap whose identifier matches an unbound line completes one cycle after acceptance with `rmp_done`=1 and `rmp_ok`=1. The line then hits on the process port at the new address and no longer hits on the network port. A further remap of that identifier fails.
- R6: A remap whose identifier is neither in a line nor in the link table completes one cycle later with `rmp_ok`=0 and issues no memory read.
- R7: An arrival into a full cache that has at least one bound line evicts a bound line and writes it to memory at its process address one cycle later, whatever the hint says.
- R8: When the cache is full and no line is bound, the line numbered by `hint_idx` is evicted. It is written to its network address, and its identifier and address are kept in the link table.
- R9: A remap that misses the lines but hits the link table raises `mem_rd_req` one cycle later with the saved address, and holds `rmp_ready` low until `mem_rd_valid`. The returned line is then installed bound, `rmp_done`/`rmp_ok` follow one cycle later, and the table entry is removed.
- R10: At most one command takes effect per cycle, with priority refill return > arrival > remap > network access > process access. A command that loses produces no response.
- R11: Among bound lines, the victim is the one least recently installed, remapped or accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Message arrival strobe |
| arr_addr | input | ADDR_W | Network buffer address of the message |
| arr_id | input | ID_W | Message identifier |
| arr_len | input | LEN_W | Message length in words |
| arr_data | input | LINE_W | Message payload |
| arr_err | output | 1 | Arrival rejected as too long |
| net_valid | input | 1 | Network-space access strobe |
| net_we | input | 1 | Network-space store |
| net_addr | input | ADDR_W | Network-space address |
| net_wdata | input | LINE_W | Network-space store data |
| net_hit | output | 1 | Network-space access hit |
| net_rdata | output | LINE_W | Network-space line data |
| proc_valid | input | 1 | Process-space access strobe |
| proc_we | input | 1 | Process-space store |
| proc_addr | input | ADDR_W | Process-space physical address |
| proc_wdata | input | LINE_W | Process-space store data |
| proc_hit | output | 1 | Process-space access hit |
| proc_rdata | output | LINE_W | Process-space line data |
| rmp_valid | input | 1 | Remap request |
| rmp_ready | output | 1 | Remap can be accepted |
| rmp_id | input | ID_W | Identifier to bind |
| rmp_paddr | input | ADDR_W | Physical process address to bind to |
| rmp_done | output | 1 | Remap finished |
| rmp_ok | output | 1 | Remap succeeded (valid with rmp_done) |
| hint_idx | input | IDX_W | Unbound line least likely to be consumed next |
| mem_wr_valid | output | 1 | Write-back strobe |
| mem_wr_addr | output | ADDR_W | Write-back address |
| mem_wr_data | output | LINE_W | Write-back line |
| mem_rd_req | output | 1 | Refill request strobe |
| mem_rd_addr | output | ADDR_W | Refill address |
| mem_rd_valid | input | 1 | Refill data returned |
| mem_rd_data | input | LINE_W | Refill line |

## Verification
The cache is filled through one sequence in which each eviction is forced under a different line population. The first eviction happens with every line unbound, which shows that the hint is used. Later evictions happen with a mix of bound and unbound lines, which shows that bound lines come first and that the hint is ignored. A final one follows a fresh process access, which separates true LRU order from install order. Remaps are applied to a cached identifier, to an evicted one and to an unknown one, so the in-place rebind, the refill path with its stalled handshake and the failure status each appear. Colliding arrival and network requests in one cycle expose the command priority.

// File: rtl/netc_pkg.sv
package netc_pkg;
   typedef enum logic [1:0] {
      LS_FREE    = 2'd0,
      LS_UNBOUND = 2'd1,
      LS_BOUND   = 2'd2
   } line_st_e;

   typedef enum logic {
      RM_IDLE = 1'b0,
      RM_WAIT = 1'b1
   } rmp_st_e;
endpackage

// File: rtl/netc_cam_match.sv
module netc_cam_match #(
   parameter int N     = 4,
   parameter int KW    = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]         ent_vld,
   input  logic [N-1:0][KW-1:0] ent_key,
   input  logic [KW-1:0]        key,
   output logic                 hit,
   output logic [IDX_W-1:0]     idx
);
   // lowest matching entry wins
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (ent_vld[i] && (ent_key[i] == key)) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/netc_victim.sv
module netc_victim #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [N-1:0]     occ,
   input  logic [N-1:0]     bnd,
   input  logic [IDX_W-1:0] hint_idx,
   output logic             free_any,
   output logic [IDX_W-1:0] free_idx,
   output logic [IDX_W-1:0] vic_idx
);
   // ages form a permutation of 0..N-1; largest = least recently touched
   logic [N-1:0][IDX_W-1:0] age_q;
   logic [IDX_W-1:0]        lru_idx;
   logic [IDX_W-1:0]        lru_age;
   logic                    lru_found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      lru_found = 1'b0;
      lru_idx   = '0;
      lru_age   = '0;
      for (int i = 0; i < N; i++) begin
         if (bnd[i] && (!lru_found || age_q[i] > lru_age)) begin
            lru_found = 1'b1;
            lru_idx   = IDX_W'(i);
            lru_age   = age_q[i];
         end
      end
      vic_idx = lru_found ? lru_idx : hint_idx;
   end
endmodule

// File: rtl/netc_ltb.sv
module netc_ltb #(
   parameter int DEPTH  = 4,
   parameter int ID_W   = 8,
   parameter int ADDR_W = 16,
   parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [ID_W-1:0]   ins_id,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic              kill_en,
   input  logic [ID_W-1:0]   kill_id,
   input  logic [ID_W-1:0]   lk_id,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_addr
);
   logic [DEPTH-1:0]             vld_q;
   logic [DEPTH-1:0][ID_W-1:0]   id_q;
   logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
   logic [PTR_W-1:0]             rr_q;
   logic                         lk_any;
   logic [PTR_W-1:0]             lk_idx;
   logic                         same_hit;
   logic [PTR_W-1:0]             same_idx;
   logic                         free_any;
   logic [PTR_W-1:0]             free_idx;
   logic [PTR_W-1:0]             slot;

   netc_cam_match #(.N(DEPTH), .KW(ID_W), .IDX_W(PTR_W)) u_lk (
      .ent_vld(vld_q), .ent_key(id_q), .key(lk_id), .hit(lk_any), .idx(lk_idx));

   netc_cam_match #(.N(DEPTH), .KW(ID_W), .IDX_W(PTR_W)) u_same (
      .ent_vld(vld_q), .ent_key(id_q), .key(ins_id), .hit(same_hit), .idx(same_idx));

   assign lk_hit  = lk_any;
   assign lk_addr = addr_q[lk_idx];

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_any = 1'b1;
            free_idx = PTR_W'(i);
         end
      end
      slot = same_hit ? same_idx : (free_any ? free_idx : rr_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         id_q   <= '0;
         addr_q <= '0;
         rr_q   <= '0;
      end else begin
         if (kill_en) begin
            for (int i = 0; i < DEPTH; i++)
               if (id_q[i] == kill_id) vld_q[i] <= 1'b0;
         end
         if (ins_en) begin
            vld_q[slot]  <= 1'b1;
            id_q[slot]   <= ins_id;
            addr_q[slot] <= ins_addr;
            if (!same_hit && !free_any)
               rr_q <= (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dual_tag_netcache.sv
module dual_tag_netcache
   import netc_pkg::*;
#(
   parameter int LINES      = 4,
   parameter int LTB_DEPTH  = 4,
   parameter int ADDR_W     = 16,
   parameter int ID_W       = 8,
   parameter int WORD_W     = 16,
   parameter int LINE_WORDS = 2,
   parameter int LEN_W      = 4,
   parameter int LINE_W     = WORD_W * LINE_WORDS,
   parameter int IDX_W      = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arr_valid,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic [ID_W-1:0]   arr_id,
   input  logic [LEN_W-1:0]  arr_len,
   input  logic [LINE_W-1:0] arr_data,
   output logic              arr_err,
   input  logic              net_valid,
   input  logic              net_we,
   input  logic [ADDR_W-1:0] net_addr,
   input  logic [LINE_W-1:0] net_wdata,
   output logic              net_hit,
   output logic [LINE_W-1:0] net_rdata,
   input  logic              proc_valid,
   input  logic              proc_we,
   input  logic [ADDR_W-1:0] proc_addr,
   input  logic [LINE_W-1:0] proc_wdata,
   output logic              proc_hit,
   output logic [LINE_W-1:0] proc_rdata,
   input  logic              rmp_valid,
   output logic              rmp_ready,
   input  logic [ID_W-1:0]   rmp_id,
   input  logic [ADDR_W-1:0] rmp_paddr,
   output logic              rmp_done,
   output logic              rmp_ok,
   input  logic [IDX_W-1:0]  hint_idx,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [LINE_W-1:0] mem_wr_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [LINE_W-1:0] mem_rd_data
);
   localparam int LTB_PTR_W = (LTB_DEPTH > 1) ? $clog2(LTB_DEPTH) : 1;

   // elaboration-time parameter checks
   if (LINES < 2)       begin : g_bad_lines $error("LINES must be at least 2"); end
   if (LTB_DEPTH < 1)   begin : g_bad_ltb   $error("LTB_DEPTH must be at least 1"); end
   if ((1 << LEN_W) <= LINE_WORDS) begin : g_bad_len $error("LEN_W too narrow"); end
   if (LINE_W != WORD_W * LINE_WORDS) begin : g_bad_lw $error("LINE_W mismatch"); end

   line_st_e                      st_q [LINES];
   logic [LINES-1:0][ADDR_W-1:0]  ntag_q;
   logic [LINES-1:0][ADDR_W-1:0]  ptag_q;
   logic [LINES-1:0][ID_W-1:0]    id_q;
   logic [LINES-1:0][LINE_W-1:0]  data_q;
   rmp_st_e                       rm_q;
   logic [ADDR_W-1:0]             pend_paddr_q;
   logic [ID_W-1:0]               pend_id_q;

   logic [LINES-1:0] occ, unb, bnd;

   for (genvar g = 0; g < LINES; g++) begin : g_state
      assign occ[g] = (st_q[g] != LS_FREE);
      assign unb[g] = (st_q[g] == LS_UNBOUND);
      assign bnd[g] = (st_q[g] == LS_BOUND);
   end

   // associative searches, one per tag kind
   logic             net_hit_c, proc_hit_c, id_hit;
   logic [IDX_W-1:0] net_idx, proc_idx, id_idx;

   netc_cam_match #(.N(LINES), .KW(ADDR_W), .IDX_W(IDX_W)) u_net_cam (
      .ent_vld(unb), .ent_key(ntag_q), .key(net_addr), .hit(net_hit_c), .idx(net_idx));
   netc_cam_match #(.N(LINES), .KW(ADDR_W), .IDX_W(IDX_W)) u_proc_cam (
      .ent_vld(bnd), .ent_key(ptag_q), .key(proc_addr), .hit(proc_hit_c), .idx(proc_idx));
   netc_cam_match #(.N(LINES), .KW(ID_W), .IDX_W(IDX_W)) u_id_cam (
      .ent_vld(unb), .ent_key(id_q), .key(rmp_id), .hit(id_hit), .idx(id_idx));

   // command arbitration: refill > arrival > remap > network > process
   logic refill_fire, arr_go, arr_ok, rmp_go, net_go, proc_go;

   assign rmp_ready   = (rm_q == RM_IDLE);
   assign refill_fire = (rm_q == RM_WAIT) && mem_rd_valid;
   assign arr_go      = arr_valid && !refill_fire;
   assign arr_ok      = arr_go && (arr_len <= LEN_W'(LINE_WORDS));
   assign rmp_go      = rmp_valid && rmp_ready && !refill_fire && !arr_valid;
   assign net_go      = net_valid && !refill_fire && !arr_valid && !(rmp_valid && rmp_ready);
   assign proc_go     = proc_valid && !refill_fire && !arr_valid &&
                        !(rmp_valid && rmp_ready) && !net_valid;

   // allocation and replacement
   logic             need_line, free_any, evict;
   logic [IDX_W-1:0] free_idx, vic_idx, alloc_idx;
   logic             touch;
   logic [IDX_W-1:0] touch_idx;

   assign need_line = arr_ok || refill_fire;
   assign alloc_idx = free_any ? free_idx : vic_idx;
   assign evict     = need_line && !free_any;

   always_comb begin
      touch     = 1'b1;
      touch_idx = alloc_idx;
      if (need_line)                   touch_idx = alloc_idx;
      else if (rmp_go && id_hit)       touch_idx = id_idx;
      else if (net_go && net_hit_c)    touch_idx = net_idx;
      else if (proc_go && proc_hit_c)  touch_idx = proc_idx;
      else                             touch     = 1'b0;
   end

   netc_victim #(.N(LINES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
      .occ(occ), .bnd(bnd), .hint_idx(hint_idx),
      .free_any(free_any), .free_idx(free_idx), .vic_idx(vic_idx));

   // link translation buffer for evicted unbound lines
   logic              ltb_ins, ltb_kill, ltb_hit;
   logic [ID_W-1:0]   ltb_kill_id;
   logic [ADDR_W-1:0] ltb_addr;

   assign ltb_ins     = evict && unb[alloc_idx];
   assign ltb_kill    = (rmp_go && id_hit) || refill_fire;
   assign ltb_kill_id = refill_fire ? pend_id_q : rmp_id;

   netc_ltb #(.DEPTH(LTB_DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .PTR_W(LTB_PTR_W)) u_ltb (
      .clk(clk), .rst_n(rst_n),
      .ins_en(ltb_ins), .ins_id(id_q[alloc_idx]), .ins_addr(ntag_q[alloc_idx]),
      .kill_en(ltb_kill), .kill_id(ltb_kill_id),
      .lk_id(rmp_id), .lk_hit(ltb_hit), .lk_addr(ltb_addr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) st_q[i] <= LS_FREE;
         ntag_q       <= '0;
         ptag_q       <= '0;
         id_q         <= '0;
         data_q       <= '0;
         rm_q         <= RM_IDLE;
         pend_paddr_q <= '0;
         pend_id_q    <= '0;
         arr_err      <= 1'b0;
         net_hit      <= 1'b0;
         net_rdata    <= '0;
         proc_hit     <= 1'b0;
         proc_rdata   <= '0;
         rmp_done     <= 1'b0;
         rmp_ok       <= 1'b0;
         mem_wr_valid <= 1'b0;
         mem_wr_addr  <= '0;
         mem_wr_data  <= '0;
         mem_rd_req   <= 1'b0;
         mem_rd_addr  <= '0;
      end else begin
         arr_err      <= 1'b0;
         net_hit      <= 1'b0;
         proc_hit     <= 1'b0;
         rmp_done     <= 1'b0;
         rmp_ok       <= 1'b0;
         mem_wr_valid <= 1'b0;
         mem_rd_req   <= 1'b0;

         if (evict) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= bnd[alloc_idx] ? ptag_q[alloc_idx] : ntag_q[alloc_idx];
            mem_wr_data  <= data_q[alloc_idx];
         end

         if (refill_fire) begin
            st_q[alloc_idx]   <= LS_BOUND;
            ptag_q[alloc_idx] <= pend_paddr_q;
            data_q[alloc_idx] <= mem_rd_data;
            rmp_done          <= 1'b1;
            rmp_ok            <= 1'b1;
            rm_q              <= RM_IDLE;
         end else if (arr_go) begin
            if (!arr_ok) begin
               arr_err <= 1'b1;
            end else begin
               st_q[alloc_idx]   <= LS_UNBOUND;
               ntag_q[alloc_idx] <= arr_addr;
               id_q[alloc_idx]   <= arr_id;
               data_q[alloc_idx] <= arr_data;
            end
         end else if (rmp_go) begin
            if (id_hit) begin
               st_q[id_idx]   <= LS_BOUND;
               ptag_q[id_idx] <= rmp_paddr;
               rmp_done       <= 1'b1;
               rmp_ok         <= 1'b1;
            end else if (ltb_hit) begin
               mem_rd_req   <= 1'b1;
               mem_rd_addr  <= ltb_addr;
               pend_paddr_q <= rmp_paddr;
               pend_id_q    <= rmp_id;
               rm_q         <= RM_WAIT;
            end else begin
               rmp_done <= 1'b1;
            end
         end else if (net_go) begin
            if (net_hit_c) begin
               net_hit   <= 1'b1;
               net_rdata <= net_we ? net_wdata : data_q[net_idx];
               if (net_we) data_q[net_idx] <= net_wdata;
            end
         end else if (proc_go) begin
            if (proc_hit_c) begin
               proc_hit   <= 1'b1;
               proc_rdata <= proc_we ? proc_wdata : data_q[proc_idx];
               if (proc_we) data_q[proc_idx] <= proc_wdata;
            end
         end
      end
   end
endmodule

// File: rtl/netc_checker.sv
module netc_checker #(
   parameter int LEN_W      = 4,
   parameter int LINE_WORDS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arr_valid,
   input logic [LEN_W-1:0] arr_len,
   input logic             arr_err,
   input logic             net_hit,
   input logic             proc_hit,
   input logic             rmp_valid,
   input logic             rmp_ready,
   input logic             rmp_done,
   input logic             mem_rd_req,
   input logic             mem_wr_valid,
   input logic             refill_fire
);
   // R10: a single command per cycle yields at most one response kind
   a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({net_hit, proc_hit, arr_err, rmp_done}));

   // R3: an oversize arrival is flagged in the next cycle
   a_r3_long_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid && !refill_fire && (arr_len > LEN_W'(LINE_WORDS))) |=> arr_err);

   // R3: a rejected arrival never evicts a line
   a_r3_reject_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      arr_err |-> !mem_wr_valid);

   // R9: while a refill is requested the remap handshake is closed
   a_r9_refill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !rmp_ready);

   // R9: the stall persists until refill data returns
   a_r9_wait_until_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!rmp_ready && !refill_fire) |=> !rmp_ready);

   // R5: an accepted remap either finishes or starts a refill next cycle
   a_r5_remap_answers: assert property (@(posedge clk) disable iff (!rst_n)
      (rmp_valid && rmp_ready && !arr_valid && !refill_fire) |=> (rmp_done || mem_rd_req));
endmodule

bind dual_tag_netcache netc_checker #(.LEN_W(LEN_W), .LINE_WORDS(LINE_WORDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_len(arr_len),
   .arr_err(arr_err), .net_hit(net_hit), .proc_hit(proc_hit),
   .rmp_valid(rmp_valid), .rmp_ready(rmp_ready), .rmp_done(rmp_done),
   .mem_rd_req(mem_rd_req), .mem_wr_valid(mem_wr_valid), .refill_fire(refill_fire));

// File: tb/dual_tag_netcache_test.sv
module dual_tag_netcache_test;
   localparam int K_WR = 0, K_RD = 1, K_NET = 2, K_PROC = 3, K_ERR = 4, K_RMP = 5;

   typedef struct {
      int          kind;
      logic [31:0] a;
      logic [31:0] d;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arr_valid = 0;
   logic [15:0] arr_addr = '0;
   logic [7:0]  arr_id = '0;
   logic [3:0]  arr_len = '0;
   logic [31:0] arr_data = '0;
   logic        arr_err;
   logic        net_valid = 0, net_we = 0;
   logic [15:0] net_addr = '0;
   logic [31:0] net_wdata = '0;
   logic        net_hit;
   logic [31:0] net_rdata;
   logic        proc_valid = 0, proc_we = 0;
   logic [15:0] proc_addr = '0;
   logic [31:0] proc_wdata = '0;
   logic        proc_hit;
   logic [31:0] proc_rdata;
   logic        rmp_valid = 0;
   logic        rmp_ready;
   logic [7:0]  rmp_id = '0;
   logic [15:0] rmp_paddr = '0;
   logic        rmp_done, rmp_ok;
   logic [1:0]  hint_idx = '0;
   logic        mem_wr_valid;
   logic [15:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        mem_rd_req;
   logic [15:0] mem_rd_addr;
   logic        mem_rd_valid = 0;
   logic [31:0] mem_rd_data = '0;

   int   n_checks = 0;
   int   n_fails  = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;  // 125 MHz

   dual_tag_netcache uut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic expect_ev(input int kind, input logic [31:0] a, input logic [31:0] d,
                            input string req);
      exp_t e;
      e.kind = kind; e.a = a; e.d = d; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic take(input int kind, input logic [31:0] a, input logic [31:0] d);
      exp_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, $sformatf("unexpected event kind %0d", kind), a, d);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == kind && e.a == a && e.d == d,
               $sformatf("%s kind %0d/%0d", e.req, kind, e.kind),
               (e.a == a) ? d : a, (e.a == a) ? e.d : e.a);
      end
   endtask

   // monitor: compares produced results against the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mem_wr_valid) take(K_WR,   {16'h0, mem_wr_addr}, mem_wr_data);
            if (mem_rd_req)   take(K_RD,   {16'h0, mem_rd_addr}, 32'h0);
            if (net_hit)      take(K_NET,  32'h0, net_rdata);
            if (proc_hit)     take(K_PROC, 32'h0, proc_rdata);
            if (arr_err)      take(K_ERR,  32'h0, 32'h0);
            if (rmp_done)     take(K_RMP,  32'h0, {31'h0, rmp_ok});
         end
      end
   end

   task automatic arrive(input logic [15:0] a, input logic [7:0] id, input logic [3:0] len,
                         input logic [31:0] d);
      arr_valid = 1; arr_addr = a; arr_id = id; arr_len = len; arr_data = d;
      @(negedge clk);
      arr_valid = 0;
   endtask

   task automatic net_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                         input bit hit, input logic [31:0] ed, input string req);
      if (hit) expect_ev(K_NET, 0, ed, req);
      net_valid = 1; net_we = we; net_addr = a; net_wdata = wd;
      @(negedge clk);
      net_valid = 0; net_we = 0;
      if (!hit) check(net_hit == 1'b0, req, {31'h0, net_hit}, 32'h0);
   endtask

   task automatic proc_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                          input bit hit, input logic [31:0] ed, input string req);
      if (hit) expect_ev(K_PROC, 0, ed, req);
      proc_valid = 1; proc_we = we; proc_addr = a; proc_wdata = wd;
      @(negedge clk);
      proc_valid = 0; proc_we = 0;
      if (!hit) check(proc_hit == 1'b0, req, {31'h0, proc_hit}, 32'h0);
   endtask

   task automatic remap(input logic [7:0] id, input logic [15:0] pa);
      rmp_valid = 1; rmp_id = id; rmp_paddr = pa;
      @(negedge clk);
      rmp_valid = 0;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(rmp_ready == 1'b1, "R1 rmp_ready", {31'h0, rmp_ready}, 1);
      check({arr_err, net_hit, proc_hit, rmp_done, mem_wr_valid, mem_rd_req} == 6'b0,
            "R1 outputs idle", {26'h0, arr_err, net_hit, proc_hit, rmp_done,
            mem_wr_valid, mem_rd_req}, 0);
      net_op(0, 16'h0100, 0, 0, 0, "R1 empty cache misses");

      // R2 arrival and network-space visibility
      arrive(16'h0100, 8'd1, 4'd2, 32'hA1A1_0001);
      net_op(0, 16'h0100, 0, 1, 32'hA1A1_0001, "R2 net load after arrival");
      proc_op(0, 16'h0100, 0, 0, 0, "R2 process space misses unbound line");

      // R3 oversize message rejected
      expect_ev(K_ERR, 0, 0, "R3 arr_err");
      arrive(16'h0200, 8'd9, 4'd3, 32'h9999_9999);
      net_op(0, 16'h0200, 0, 0, 0, "R3 nothing stored");

      // R4 network store
      net_op(1, 16'h0100, 32'hB1B1_0001, 1, 32'hB1B1_0001, "R4 net store");
      net_op(0, 16'h0100, 0, 1, 32'hB1B1_0001, "R4 net load after store");

      // fill the cache with unbound lines
      arrive(16'h0110, 8'd2, 4'd2, 32'hA2A2_0002);
      arrive(16'h0120, 8'd3, 4'd1, 32'hA3A3_0003);
      arrive(16'h0130, 8'd4, 4'd2, 32'hA4A4_0004);

      // R8 no bound lines: hinted line evicted to its network address
      hint_idx = 2'd2;
      expect_ev(K_WR, 32'h0120, 32'hA3A3_0003, "R8 hinted eviction");
      arrive(16'h0140, 8'd5, 4'd2, 32'hA5A5_0005);

      // R9 remap of evicted message refills from saved address
      expect_ev(K_RD, 32'h0120, 0, "R9 refill request");
      remap(8'd3, 16'h0C00);
      for (int k = 0; k < 3; k++) begin
         check(rmp_ready == 1'b0, "R9 handshake stalled", {31'h0, rmp_ready}, 0);
         @(negedge clk);
      end
      hint_idx = 2'd3;
      expect_ev(K_WR, 32'h0130, 32'hA4A4_0004, "R8 eviction at refill");
      expect_ev(K_RMP, 0, 1, "R9 remap success after refill");
      mem_rd_valid = 1; mem_rd_data = 32'hA3A3_0003;
      @(negedge clk);
      mem_rd_valid = 0;
      check(rmp_ready == 1'b1, "R9 handshake reopened", {31'h0, rmp_ready}, 1);
      proc_op(0, 16'h0C00, 0, 1, 32'hA3A3_0003, "R9 refilled line bound");
      expect_ev(K_RMP, 0, 0, "R9 link entry removed");
      remap(8'd3, 16'h0E00);

      // R5 in-place rebind
      expect_ev(K_RMP, 0, 1, "R5 remap hit");
      remap(8'd1, 16'h0800);
      proc_op(0, 16'h0800, 0, 1, 32'hB1B1_0001, "R5 process load after remap");
      net_op(0, 16'h0100, 0, 0, 0, "R5 network tag dropped");
      expect_ev(K_RMP, 0, 0, "R5 second remap fails");
      remap(8'd1, 16'h0900);

      // R6 unknown identifier
      expect_ev(K_RMP, 0, 0, "R6 unknown id fails");
      remap(8'd77, 16'h0A00);

      // R11 refresh line at 0x0C00, so 0x0800 becomes LRU; R7 hint ignored
      proc_op(0, 16'h0C00, 0, 1, 32'hA3A3_0003, "R11 refresh access");
      hint_idx = 2'd1;
      expect_ev(K_WR, 32'h0800, 32'hB1B1_0001, "R7 R11 LRU bound eviction");
      arrive(16'h0150, 8'd6, 4'd2, 32'hA6A6_0006);

      // R10 arrival beats a network access in the same cycle
      expect_ev(K_WR, 32'h0C00, 32'hA3A3_0003, "R7 bound line before unbound");
      arr_valid = 1; arr_addr = 16'h0160; arr_id = 8'd7; arr_len = 4'd2;
      arr_data = 32'hA7A7_0007;
      net_valid = 1; net_we = 0; net_addr = 16'h0110;
      @(negedge clk);
      arr_valid = 0; net_valid = 0;
      check(net_hit == 1'b0, "R10 losing network access dropped", {31'h0, net_hit}, 0);
      net_op(0, 16'h0110, 0, 1, 32'hA2A2_0002, "R10 line still present");
      net_op(0, 16'h0160, 0, 1, 32'hA7A7_0007, "R10 arrival took effect");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule